// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This block takes one 512-bit message block and produces the word schedule that the SM3 compression rounds consume. Each clock in which the consumer is ready, it presents one round's pair of words: the expanded word W_j and the derived word W'_j = W_j ^ W_{j+4}, for j running from 0 to 63. The sixteen input words are formed from the block's bytes in big-endian order. Words beyond the sixteenth follow the SM3 recurrence, built on the P1 permutation.

Only a sliding window of sixteen words is kept. The head of the window is W_j. The word four places further on supplies the derived word. When an output pair is taken, the window shifts by one word and the next expanded word enters at the tail, so the full table of 68 words is never stored. The input side accepts a block only when the unit is idle, which is the cycle after the last pair has been handed over. The output side uses a valid/ready handshake and carries a last flag.

Top module: `sm3_msg_expand`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Byte i of the block sits in in_block[8*i+7:8*i]. Input word k is {byte 4k, byte 4k+1, byte 4k+2, byte 4k+3}, with byte 4k in bits 31:24.
- R3: For j from 0 to 15, out_w equals input word j.
- R4: For j from 16 to 63, out_w equals P1(W_{j-16} ^ W_{j-9} ^ rol(W_{j-3},15)) ^ rol(W_{j-13},7) ^ W_{j-6}, where P1(x) = x ^ rol(x,15) ^ rol(x,23).
- R5: out_wp equals W_j ^ W_{j+4} for every j. For j from 60 to 63 this uses the expanded words 64 to 67.
- R6: Exactly 64 pairs are emitted per block, in order of j. out_last is 1 on the pair with j = 63 and 0 on every other pair.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_w and out_wp hold their values and the sequence does not advance.
- R8: in_ready is 0 from the acceptance of a block until its last pair is handed over, and in_valid has no effect during that time. in_ready is 1 again in the cycle after that handshake.
- R9: out_valid becomes 1 in the cycle after a block is accepted (in_valid and in_ready both 1 at a clock edge).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A message block is offered |
| in_ready | output | 1 | Unit is idle and takes a block |
| in_block | input | 512 | Message block, byte i in bits 8i+7:8i |
| out_valid | output | 1 | A word pair is presented |
| out_ready | input | 1 | Consumer takes the pair |
| out_w | output | 32 | Expanded word W_j |
| out_wp | output | 32 | Derived word W_j ^ W_{j+4} |
| out_last | output | 1 | Pair with j = 63 |

## Verification
A single 1 bit is walked through all 512 positions of the block. Each such block checks all 64 pairs of both words. This separates an error in one tap or rotate amount of the recurrence from an error in the byte order, because each bit reaches the outputs along a different path. An all-zero block, an all-ones block and an ascending-byte block check the constant and byte-order cases. Several pseudo-random blocks are then run with periodic consumer stalls and with a different block held on the input while busy, to show that stalls keep the outputs steady and that offers during a block are ignored.

// File: rtl/sm3_msg_expand.sv
module sm3_msg_expand #(
  parameter int NUM_OUT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [511:0] in_block,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [31:0]  out_w,
  output logic [31:0]  out_wp,
  output logic         out_last
);
  localparam int NW = 16;
  localparam int CW = $clog2(NUM_OUT);

  logic [31:0]   win [NW];
  logic          busy;
  logic [CW-1:0] cnt;

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  wire [31:0] mix  = win[0] ^ win[7] ^ rol(win[13], 15);
  wire [31:0] p1   = mix ^ rol(mix, 15) ^ rol(mix, 23);
  wire [31:0] nxt  = p1 ^ rol(win[3], 7) ^ win[10];
  wire        take = in_valid && in_ready;
  wire        fire = out_valid && out_ready;

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_w     = win[0];
  assign out_wp    = win[0] ^ win[4];
  assign out_last  = busy && (cnt == CW'(NUM_OUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      for (int k = 0; k < NW; k++) win[k] <= '0;
    end else if (take) begin
      busy <= 1'b1;
      cnt  <= '0;
      for (int k = 0; k < NW; k++)
        win[k] <= {in_block[32*k +: 8], in_block[32*k+8 +: 8],
                   in_block[32*k+16 +: 8], in_block[32*k+24 +: 8]};
    end else if (fire) begin
      cnt <= cnt + 1'b1;
      if (out_last) busy <= 1'b0;
      for (int k = 0; k < NW - 1; k++) win[k] <= win[k+1];
      win[NW-1] <= nxt;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_w) && $stable(out_wp));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R9
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && !out_last);

  // R6
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);

  // R6
  last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && out_last |=> out_last);
endmodule

// File: tb/tb_sm3_msg_expand.sv
`timescale 1ns/1ps
module tb_sm3_msg_expand;
  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic [511:0] in_block = '0;
  logic in_ready, out_valid, out_last;
  logic [31:0] out_w, out_wp;
  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] ew [68];

  always #2 clk = ~clk;

  sm3_msg_expand dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .out_valid(out_valid), .out_ready(out_ready), .out_w(out_w),
    .out_wp(out_wp), .out_last(out_last));

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic build(input logic [511:0] b);
    for (int k = 0; k < 16; k++)
      ew[k] = {b[32*k +: 8], b[32*k+8 +: 8], b[32*k+16 +: 8], b[32*k+24 +: 8]};
    for (int j = 16; j < 68; j++) begin
      logic [31:0] t;
      t = ew[j-16] ^ ew[j-9] ^ rl(ew[j-3], 15);
      ew[j] = t ^ rl(t, 15) ^ rl(t, 23) ^ rl(ew[j-13], 7) ^ ew[j-6];
    end
  endtask

  task automatic run_block(input logic [511:0] b, input bit stall, input bit junk);
    build(b);
    @(negedge clk);
    in_valid = 1; in_block = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk(out_valid === 1'b1, "R9 valid after accept", {31'd0, out_valid}, 32'd1);
    if (junk) in_block = ~b; else in_valid = 0;
    for (int j = 0; j < 64; j++) begin
      if (stall && (j % 3 == 1)) begin
        out_ready = 0;
        @(negedge clk);
        chk(out_valid && out_w === ew[j] && out_wp === (ew[j] ^ ew[j+4]),
            "R7 hold under stall", out_w, ew[j]);
      end
      out_ready = 1;
      if (j == 63) in_valid = 0;
      if (j == 32) chk(in_ready === 1'b0, "R8 busy", {31'd0, in_ready}, 32'd0);
      chk(out_valid === 1'b1, "R6 pair present", {31'd0, out_valid}, 32'd1);
      chk(out_w === ew[j], j < 16 ? "R3 input word" : "R4 recurrence", out_w, ew[j]);
      chk(out_wp === (ew[j] ^ ew[j+4]), "R5 derived word", out_wp, ew[j] ^ ew[j+4]);
      chk(out_last === (j == 63), "R6 last flag", {31'd0, out_last}, {31'd0, j == 63});
      @(negedge clk);
    end
    out_ready = 0;
    chk(out_valid === 1'b0, "R6 no 65th pair", {31'd0, out_valid}, 32'd0);
    chk(in_ready === 1'b1, "R8 ready again", {31'd0, in_ready}, 32'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] b;
    logic [31:0] seed;
    #9 rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk(in_ready === 1'b1, "R1 reset ready", {31'd0, in_ready}, 32'd1);

    for (int i = 0; i < 64; i++) b[8*i +: 8] = 8'(i);
    build(b);
    chk(ew[0] === 32'h00010203, "R2 byte order", ew[0], 32'h00010203);
    chk(ew[15] === 32'h3c3d3e3f, "R2 byte order", ew[15], 32'h3c3d3e3f);
    run_block(b, 0, 0);
    run_block('0, 0, 0);
    run_block('1, 1, 0);
    for (int p = 0; p < 512; p++) begin
      b = '0; b[p] = 1'b1;
      run_block(b, 0, 0);
    end
    seed = 32'h1234_5678;
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 16; k++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        b[32*k +: 32] = seed;
      end
      run_block(b, 1, 1);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule